// File: doc/BRIEF.md
# UART baud tick generator

This block produces the baud-rate strobe for a UART. The strobe is built from one of two reference streams. The first is the system clock divided by a fixed four. The second is a crystal reference, presented as a one-cycle pulse per crystal period and synchronous to the system clock, passed through a small coded prescaler. The chosen reference stream feeds a 23-bit integer divider. That divider emits a one-cycle `baud_tick` every N+1 reference strobes.

All stages are clock-enable strobes in the single system clock domain. No derived clocks exist. A single 32-bit control word sets the divider value, the divider enable, the reference select and the prescaler code. The word is written through a simple write strobe and is always visible on the read bus. A write is taken only while the transmitter reports it is empty. Every accepted write restarts every counter, so the new rate begins from a clean phase.

Top module: `uart_baud_tick_gen`

## Requirements
- R1: A synchronous active-high `rst` clears the control word to zero and holds `baud_tick` low in the cycle after reset.
- R2: Control word layout: bits 22:0 are the divider value N, bit 23 is the divider enable, bit 24 is the reference select and bits 27:26 are the prescaler code. Bits 25 and 31:28 read as zero whatever was written. `rd_data` always shows the stored word.
- R3: With select = 0, the reference strobe occurs every 4 system cycles. After an accepted write, the first tick appears exactly 4(N+1) cycles after the write edge. Later ticks follow at that same period.
- R4: N = 0 is legal and gives a tick after every reference strobe.
- R5: With select = 1, the prescaler code sets the division of `xtal_pulse`: code 0 divides by 3, code 1 by 1, code 2 by 2 and code 3 by 2. A tick appears in the cycle after each D*(N+1)-th crystal pulse counted from the write.
- R6: With the enable bit clear, `baud_tick` stays low.
- R7: A write while `tx_empty` is low is ignored. The stored word is unchanged and the tick phase is not disturbed.
- R8: An accepted write restarts the prescaler, the fixed divide-by-4 counter and the divider. No tick left over from the old setting appears in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| tx_empty | input | 1 | Transmitter idle; writes are taken only while high |
| xtal_pulse | input | 1 | One-cycle strobe per crystal reference period |
| rd_data | output | 32 | Stored control word |
| baud_tick | output | 1 | One-cycle baud strobe |

## Verification
The checks assume that `xtal_pulse` is already synchronous to `clk` and is a plain strobe. They also assume that `wr_en` is sampled only at clock edges, together with a stable `tx_empty`. The stimulus meets these assumptions. It raises the crystal strobe for one cycle in every third cycle from a cycle counter, and it changes the write signals only on falling edges. All crystal-path timing in the bench is derived from the known positions of those pulses. A write refused because `tx_empty` is low is placed in the middle of a running tick train. This shows that the refusal leaves both the stored word and the tick phase untouched.

// File: rtl/ubg_pkg.sv
package ubg_pkg;
    parameter int DIV_W   = 23;
    parameter int REG_W   = 32;
    parameter int PRE_W   = 2;
    localparam int EN_BIT  = DIV_W;
    localparam int SRC_BIT = DIV_W + 1;
    localparam int PRE_LSB = DIV_W + 3;
    localparam int PRE_CW  = 2;

    // Stored bits: divider value, enable, select, prescaler code; the rest stay zero.
    localparam logic [REG_W-1:0] REG_MASK =
        {{(REG_W-PRE_LSB-PRE_W){1'b0}}, {PRE_W{1'b1}}, 1'b0, {(DIV_W+2){1'b1}}};

    // Last count of the crystal prescaler for a given code (ratio minus one).
    function automatic logic [PRE_CW-1:0] pre_last(input logic [PRE_W-1:0] code);
        case (code)
            2'd0:    pre_last = 2'd2;
            2'd1:    pre_last = 2'd0;
            default: pre_last = 2'd1;
        endcase
    endfunction
endpackage

// File: rtl/ubg_ctrl_reg.sv
module ubg_ctrl_reg
    import ubg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             tx_empty,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             restart,
    output logic [DIV_W-1:0] div_n,
    output logic             div_on,
    output logic             src_xtal,
    output logic [PRE_W-1:0] pre_code
);
    typedef struct packed {
        logic [REG_W-1:0] word;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    accept;

    always_comb begin
        accept = wr_en && tx_empty;
        st_d   = st_q;
        if (accept) begin
            st_d.word = wr_data & REG_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = st_q.word;
    assign restart  = accept;
    assign div_n    = st_q.word[DIV_W-1:0];
    assign div_on   = st_q.word[EN_BIT];
    assign src_xtal = st_q.word[SRC_BIT];
    assign pre_code = st_q.word[PRE_LSB +: PRE_W];

    // R1
    reset_clears_word_chk: assert property (@(posedge clk)
        rst |=> (rd_data == '0));

    // R7
    blocked_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !tx_empty) |=> $stable(rd_data));
endmodule

// File: rtl/ubg_ref_sel.sv
module ubg_ref_sel
    import ubg_pkg::*;
#(
    parameter int BUS_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             src_xtal,
    input  logic [PRE_W-1:0] pre_code,
    input  logic             xtal_pulse,
    output logic             ref_en
);
    localparam int BUS_CW = (BUS_DIV > 1) ? $clog2(BUS_DIV) : 1;
    localparam logic [BUS_CW-1:0] BUS_LAST = BUS_CW'(BUS_DIV - 1);

    typedef struct packed {
        logic [BUS_CW-1:0] bus_cnt;
        logic [PRE_CW-1:0] pre_cnt;
    } ref_st_t;

    ref_st_t           st_d, st_q;
    logic              bus_en;
    logic              xtal_en;
    logic [PRE_CW-1:0] pre_end;

    always_comb begin
        pre_end = pre_last(pre_code);
        bus_en  = (st_q.bus_cnt == BUS_LAST);
        xtal_en = xtal_pulse && (st_q.pre_cnt == pre_end);
        st_d    = st_q;
        if (restart) begin
            st_d.bus_cnt = '0;
            st_d.pre_cnt = '0;
        end else begin
            st_d.bus_cnt = bus_en ? '0 : st_q.bus_cnt + 1'b1;
            if (xtal_pulse) begin
                st_d.pre_cnt = xtal_en ? '0 : st_q.pre_cnt + 1'b1;
            end
        end
        ref_en = src_xtal ? xtal_en : bus_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    bus_strobe_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        bus_en |=> !bus_en);

    // R5
    xtal_unit_ratio_chk: assert property (@(posedge clk) disable iff (rst)
        (src_xtal && pre_code == 2'd1 && xtal_pulse) |-> ref_en);
endmodule

// File: rtl/ubg_divider.sv
module ubg_divider
    import ubg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             div_on,
    input  logic             ref_en,
    input  logic [DIV_W-1:0] div_n,
    output logic             baud_tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (restart || !div_on) begin
            st_d.cnt = '0;
        end else if (ref_en) begin
            if (st_q.cnt == div_n) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign baud_tick = st_q.tick;

    // R1
    reset_quiet_tick_chk: assert property (@(posedge clk)
        rst |=> !baud_tick);

    // R6
    tick_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        baud_tick |-> ($past(div_on) && $past(ref_en)));

    // R8
    restart_drops_tick_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> !baud_tick);
endmodule

// File: rtl/uart_baud_tick_gen.sv
module uart_baud_tick_gen
    import ubg_pkg::*;
#(
    parameter int BUS_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             tx_empty,
    input  logic             xtal_pulse,
    output logic [REG_W-1:0] rd_data,
    output logic             baud_tick
);
    logic             restart;
    logic [DIV_W-1:0] div_n;
    logic             div_on;
    logic             src_xtal;
    logic [PRE_W-1:0] pre_code;
    logic             ref_en;

    ubg_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .tx_empty (tx_empty),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .restart  (restart),
        .div_n    (div_n),
        .div_on   (div_on),
        .src_xtal (src_xtal),
        .pre_code (pre_code)
    );

    ubg_ref_sel #(.BUS_DIV(BUS_DIV)) u_ref (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .src_xtal   (src_xtal),
        .pre_code   (pre_code),
        .xtal_pulse (xtal_pulse),
        .ref_en     (ref_en)
    );

    ubg_divider u_div (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .div_on    (div_on),
        .ref_en    (ref_en),
        .div_n     (div_n),
        .baud_tick (baud_tick)
    );
endmodule

// File: tb/uart_baud_tick_gen_tb_top.sv
module uart_baud_tick_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        tx_empty = 1'b1;
    logic        xtal_pulse = 1'b0;
    logic [31:0] rd_data;
    logic        baud_tick;

    int    cyc = 0;
    int    tests = 0;
    int    fails = 0;
    int    extra = 0;
    bit    mon_on = 1'b0;
    bit    done = 1'b0;
    string mon_req = "R3";
    int    exp_q[$];

    uart_baud_tick_gen dut_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .tx_empty   (tx_empty),
        .xtal_pulse (xtal_pulse),
        .rd_data    (rd_data),
        .baud_tick  (baud_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    // Crystal strobe: one cycle high in every cycle whose count is a multiple of 3.
    always @(negedge clk) xtal_pulse <= (cyc % 3 == 0);

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: every tick seen while armed is compared against the front of the queue.
    always @(negedge clk) begin
        if (mon_on && baud_tick) begin
            if (exp_q.size() == 0) begin
                extra++;
                check(1'b0, mon_req, "unexpected tick at cycle", cyc, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(cyc == e, mon_req, "tick cycle", cyc, e);
            end
        end
    end

    function automatic logic [31:0] mk(input int n, input bit en, input bit src, input int code);
        mk = (32'(code & 3) << 26) | (32'(src) << 24) | (32'(en) << 23) | 32'(n);
    endfunction

    task automatic write_cfg(input logic [31:0] v, input logic txe, output int c0);
        @(negedge clk);
        wr_en    = 1'b1;
        wr_data  = v;
        tx_empty = txe;
        @(negedge clk);
        wr_en    = 1'b0;
        tx_empty = 1'b1;
        c0       = cyc;
    endtask

    task automatic finish_window(input int last, input string req);
        while (cyc < last + 3) @(negedge clk);
        check(exp_q.size() == 0, req, "missing ticks", exp_q.size(), 0);
        check(extra == 0, req, "extra ticks", extra, 0);
        mon_on = 1'b0;
        exp_q.delete();
        extra = 0;
    endtask

    // R3 R4 R8: fixed divide-by-4 path.
    task automatic run_bus(input int n, input int k, input string req);
        int c0;
        int last;
        mon_on = 1'b0;
        exp_q.delete();
        write_cfg(mk(n, 1'b1, 1'b0, 0), 1'b1, c0);
        mon_req = req;
        last = c0;
        for (int i = 1; i <= k; i++) begin
            last = c0 + 4 * (n + 1) * i;
            exp_q.push_back(last);
        end
        mon_on = 1'b1;
        finish_window(last, req);
    endtask

    // R5: crystal path with prescaler code.
    task automatic run_xtal(input int code, input int n, input int k);
        int c0;
        int m1;
        int d;
        int last;
        d = (code == 0) ? 3 : (code == 1) ? 1 : 2;
        mon_on = 1'b0;
        exp_q.delete();
        write_cfg(mk(n, 1'b1, 1'b1, code), 1'b1, c0);
        mon_req = "R5";
        m1 = c0 + ((3 - (c0 % 3)) % 3);
        last = c0;
        for (int i = 1; i <= k; i++) begin
            last = m1 + 3 * (i * d * (n + 1) - 1) + 1;
            exp_q.push_back(last);
        end
        mon_on = 1'b1;
        finish_window(last, "R5");
    endtask

    initial begin
        int c0;
        int last;
        logic [31:0] cfg;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(rd_data == 32'h0, "R1", "word after reset", rd_data, 0);
        check(baud_tick == 1'b0, "R1", "tick after reset", baud_tick, 0);

        // R2: reserved bits drop out of the stored word.
        write_cfg(32'hFFFF_FFFF, 1'b1, c0);
        check(rd_data == 32'h0DFF_FFFF, "R2", "readback all ones", rd_data, 32'h0DFF_FFFF);
        write_cfg(mk(5, 1'b0, 1'b1, 2), 1'b1, c0);
        check(rd_data == 32'h0900_0005, "R2", "readback fields", rd_data, 32'h0900_0005);

        run_bus(0, 6, "R4");
        run_bus(2, 4, "R3");
        run_bus(9, 3, "R8");
        run_bus(1, 5, "R3");

        run_xtal(0, 1, 3);
        run_xtal(1, 0, 5);
        run_xtal(1, 3, 3);
        run_xtal(2, 2, 3);
        run_xtal(3, 1, 3);

        // R6: divider disabled, no tick over a long window.
        write_cfg(mk(0, 1'b0, 1'b0, 0), 1'b1, c0);
        mon_req = "R6";
        mon_on = 1'b1;
        finish_window(c0 + 40, "R6");

        // R7: refused write in mid-train leaves word and phase intact.
        cfg = mk(1, 1'b1, 1'b0, 0);
        write_cfg(cfg, 1'b1, c0);
        mon_req = "R7";
        last = c0;
        for (int i = 1; i <= 6; i++) begin
            last = c0 + 8 * i;
            exp_q.push_back(last);
        end
        mon_on = 1'b1;
        while (cyc < c0 + 13) @(negedge clk);
        write_cfg(mk(7, 1'b1, 1'b1, 0), 1'b0, c0);
        check(rd_data == cfg, "R7", "word after refused write", rd_data, cfg);
        finish_window(last, "R7");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule